// File: doc/BRIEF.md
# Descriptor list walker

This block drives a scatter-gather DMA engine from a chain of descriptors kept in system memory. Software writes the address of the first descriptor and sets the run bit. The walker then reads each descriptor one word at a time over a simple request/acknowledge read port. A descriptor that hardware owns goes to a downstream dispatcher. When the dispatcher reports completion, the walker writes the descriptor's control word back over a request/acknowledge write port and follows the next-pointer.

Software can choose what happens at the end of the chain. Polling makes the walker re-read a descriptor it does not yet own, at a programmable interval, and carry on without software help. Park mode leaves ownership with hardware on write-back, so a ring of descriptors repeats. A self-clearing abort bit stops the walk cleanly. Completions can latch an interrupt through a mask that sits ahead of the status latch.

Top module: `desc_walker`

## Requirements
- R1: After reset, the four registers read zero: control at byte offset 0x0, head pointer at 0x4, poll interval at 0x8 and status at 0xC. Control bits 31:5 always read zero, whatever was written.
- R2: Control bit 0 (run) and bit 2 (abort) can only be set by writing 1; writing 0 to them does nothing. Bit 1 (poll enable), bit 3 (interrupt mask) and bit 4 (park) are plain read/write.
- R3: A descriptor is four words at pointer+0x0 (next pointer), +0x4 (buffer address), +0x8 (length) and +0xC (control word). Control bit 31 is the ownership flag and bit 0 is the chain-end flag. Starting at the head pointer, every owned descriptor's address and length go to the dispatcher in chain order.
- R4: After the dispatcher's done pulse, the control word is written back to pointer+0xC. With park clear, bit 31 is cleared and every other bit is unchanged.
- R5: With polling off, finishing a chain-end descriptor clears run, and no further memory reads follow.
- R6: With polling off, fetching a descriptor whose ownership flag is 0 clears run, and that descriptor is not dispatched.
- R7: With polling on, an unowned descriptor keeps run at 1. Its first word is requested again every N+5 cycles, where N is the poll interval and 0 counts as 1. The walk resumes once the flag reads 1.
- R8: If poll enable is cleared while the walker is polling, the next re-read that finds the flag at 0 clears run.
- R9: With park set, write-back keeps bit 31 set, so a ring of descriptors is dispatched again and again. Once park is cleared, the ring stops after its descriptors have been written back unowned.
- R10: Setting abort ends the walk. A memory request that is already in progress stays asserted with a stable address until it is acknowledged. Abort and run then clear together, and no new request follows.
- R11: A write-back sets status bit 0 only while the mask (control bit 3) is 1. Events that occur while the mask is 0 are never latched. The irq output is status bit 0 ANDed with the mask. Writing 1 to status bit 0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset (word aligned) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mrd_req | output | 1 | Memory read request, held until acknowledged |
| mrd_addr | output | AW | Memory read byte address |
| mrd_ack | input | 1 | Memory read acknowledge, data valid |
| mrd_data | input | 32 | Memory read data |
| mwr_req | output | 1 | Memory write request, held until acknowledged |
| mwr_addr | output | AW | Memory write byte address |
| mwr_data | output | 32 | Memory write data |
| mwr_ack | input | 1 | Memory write acknowledge |
| disp_valid | output | 1 | Descriptor offered to dispatcher |
| disp_ready | input | 1 | Dispatcher accepts descriptor |
| disp_addr | output | 32 | Buffer address of offered descriptor |
| disp_len | output | 32 | Length of offered descriptor |
| disp_done | input | 1 | Dispatcher finished the accepted descriptor |
| irq | output | 1 | Interrupt request |

## Verification
A walker that holds a wrong pointer or beat count shows up on the read port within the next fetch. The read addresses step away from the expected pointer+offset pattern, and the dispatcher receives the wrong address or length within a few cycles. A wrong ownership or park decision shows up as a write-back word with the wrong bit 31, or as an extra or missing dispatch, on the same list pass. A stuck poll counter changes the spacing of repeated first-word reads by whole cycles. A broken abort path leaves the abort bit set, or lets a read request drop before its acknowledge, on the cycle it happens. The bench sweeps two poll intervals and both park settings. It aborts in two phases, one during a stalled read and one while a descriptor is with the dispatcher.

// File: rtl/dw_pkg.sv
package dw_pkg;
  typedef enum logic [2:0] {
    WS_IDLE,
    WS_FETCH,
    WS_CHECK,
    WS_ISSUE,
    WS_BUSY,
    WS_WBACK,
    WS_POLL
  } walk_st_e;

  localparam int unsigned OWN_POS = 31;
  localparam int unsigned END_POS = 0;
  localparam int unsigned LAST_BEAT = 3;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_HEAD = 2'd1;
  localparam logic [1:0] SEL_IVL  = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

  // bit order matches control register bits 4..0
  typedef struct packed {
    logic park;
    logic gie;
    logic abort;
    logic poll;
    logic run;
  } ctrl_bits_t;
endpackage

// File: rtl/dw_regs.sv
module dw_regs
  import dw_pkg::*;
#(
  parameter int unsigned AW  = 32,
  parameter int unsigned PCW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic             hw_run_clr,
  input  logic             hw_abort_done,
  input  logic             done_event,
  output ctrl_bits_t       ctrl,
  output logic [AW-1:0]    head_ptr,
  output logic [PCW-1:0]   poll_ivl,
  output logic             irq_stat
);
  localparam int unsigned CTRL_W = $bits(ctrl_bits_t);

  ctrl_bits_t     ctrl_q, ctrl_d;
  logic [AW-1:0]  head_q, head_d;
  logic [PCW-1:0] ivl_q, ivl_d;
  logic           stat_q, stat_d;
  logic           aligned;
  logic [1:0]     sel;
  logic           wr_ok;

  assign aligned = (addr[1:0] == 2'b00);
  assign sel     = addr[3:2];
  assign wr_ok   = wr_en && aligned;

  always_comb begin
    ctrl_d = ctrl_q;
    head_d = head_q;
    ivl_d  = ivl_q;
    stat_d = stat_q;
    if (wr_ok && sel == SEL_CTRL) begin
      ctrl_d.park = wdata[4];
      ctrl_d.gie  = wdata[3];
      ctrl_d.poll = wdata[1];
      if (wdata[0]) ctrl_d.run   = 1'b1;
      if (wdata[2]) ctrl_d.abort = 1'b1;
    end
    if (hw_run_clr) ctrl_d.run = 1'b0;
    if (hw_abort_done) begin
      ctrl_d.run   = 1'b0;
      ctrl_d.abort = 1'b0;
    end
    if (wr_ok && sel == SEL_HEAD) head_d = wdata[AW-1:0];
    if (wr_ok && sel == SEL_IVL)  ivl_d  = wdata[PCW-1:0];
    if (wr_ok && sel == SEL_STAT && wdata[0]) stat_d = 1'b0;
    if (done_event && ctrl_q.gie) stat_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      head_q <= '0;
      ivl_q  <= '0;
      stat_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      head_q <= head_d;
      ivl_q  <= ivl_d;
      stat_q <= stat_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (aligned) begin
      case (sel)
        SEL_CTRL: rdata = {{(32-CTRL_W){1'b0}}, ctrl_q};
        SEL_HEAD: rdata = 32'(head_q);
        SEL_IVL:  rdata = 32'(ivl_q);
        default:  rdata = {31'b0, stat_q};
      endcase
    end
  end

  assign ctrl     = ctrl_q;
  assign head_ptr = head_q;
  assign poll_ivl = ivl_q;
  assign irq_stat = stat_q;
endmodule

// File: rtl/dw_poll_timer.sv
module dw_poll_timer #(
  parameter int unsigned PCW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           tick,
  input  logic [PCW-1:0] ivl,
  output logic           expire
);
  logic [PCW-1:0] cnt_q, cnt_d;
  logic [PCW-1:0] eff;
  logic           cnt_en;

  assign eff    = (ivl == '0) ? PCW'(1) : ivl;
  assign cnt_en = load || (tick && cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)                     cnt_d = eff;
    else if (tick && cnt_q != '0) cnt_d = cnt_q - PCW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire = tick && (cnt_q <= PCW'(1));
endmodule

// File: rtl/dw_walker.sv
module dw_walker
  import dw_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          poll_en,
  input  logic          park,
  input  logic          abort_req,
  input  logic [AW-1:0] head_ptr,
  output logic          mrd_req,
  output logic [AW-1:0] mrd_addr,
  input  logic          mrd_ack,
  input  logic [31:0]   mrd_data,
  output logic          mwr_req,
  output logic [AW-1:0] mwr_addr,
  output logic [31:0]   mwr_data,
  input  logic          mwr_ack,
  output logic          disp_valid,
  input  logic          disp_ready,
  output logic [31:0]   disp_addr,
  output logic [31:0]   disp_len,
  input  logic          disp_done,
  input  logic          poll_expire,
  output logic          poll_load,
  output logic          polling,
  output logic          run_clr,
  output logic          abort_done,
  output logic          done_event,
  output logic          own_flag
);
  localparam logic [AW-1:0] WB_OFS = AW'(12);
  localparam logic [31:0]   OWN_M  = 32'(1) << OWN_POS;

  walk_st_e      st_q, st_d;
  logic [AW-1:0] cur_q, cur_d;
  logic [1:0]    beat_q, beat_d;
  logic [31:0]   nxt_q, nxt_d;
  logic [31:0]   buf_q, buf_d;
  logic [31:0]   len_q, len_d;
  logic [31:0]   cw_q, cw_d;

  assign mrd_addr  = cur_q + {{(AW-4){1'b0}}, beat_q, 2'b00};
  assign mwr_addr  = cur_q + WB_OFS;
  assign mwr_data  = park ? (cw_q | OWN_M) : (cw_q & ~OWN_M);
  assign disp_addr = buf_q;
  assign disp_len  = len_q;
  assign own_flag  = cw_q[OWN_POS];

  always_comb begin
    st_d       = st_q;
    cur_d      = cur_q;
    beat_d     = beat_q;
    nxt_d      = nxt_q;
    buf_d      = buf_q;
    len_d      = len_q;
    cw_d       = cw_q;
    mrd_req    = 1'b0;
    mwr_req    = 1'b0;
    disp_valid = 1'b0;
    poll_load  = 1'b0;
    polling    = 1'b0;
    run_clr    = 1'b0;
    abort_done = 1'b0;
    done_event = 1'b0;
    case (st_q)
      WS_IDLE: begin
        if (abort_req) begin
          abort_done = 1'b1;
        end else if (run) begin
          cur_d  = head_ptr;
          beat_d = 2'd0;
          st_d   = WS_FETCH;
        end
      end
      WS_FETCH: begin
        mrd_req = 1'b1;
        if (mrd_ack) begin
          case (beat_q)
            2'd0:    nxt_d = mrd_data;
            2'd1:    buf_d = mrd_data;
            2'd2:    len_d = mrd_data;
            default: cw_d  = mrd_data;
          endcase
          beat_d = beat_q + 2'd1;
          if (abort_req) begin
            abort_done = 1'b1;
            st_d       = WS_IDLE;
          end else if (beat_q == 2'(LAST_BEAT)) begin
            st_d = WS_CHECK;
          end
        end
      end
      WS_CHECK: begin
        if (abort_req) begin
          abort_done = 1'b1;
          st_d       = WS_IDLE;
        end else if (cw_q[OWN_POS]) begin
          st_d = WS_ISSUE;
        end else if (poll_en) begin
          poll_load = 1'b1;
          st_d      = WS_POLL;
        end else begin
          run_clr = 1'b1;
          st_d    = WS_IDLE;
        end
      end
      WS_ISSUE: begin
        if (abort_req) begin
          abort_done = 1'b1;
          st_d       = WS_IDLE;
        end else begin
          disp_valid = 1'b1;
          if (disp_ready) st_d = WS_BUSY;
        end
      end
      WS_BUSY: begin
        if (abort_req) begin
          abort_done = 1'b1;
          st_d       = WS_IDLE;
        end else if (disp_done) begin
          st_d = WS_WBACK;
        end
      end
      WS_WBACK: begin
        mwr_req = 1'b1;
        if (mwr_ack) begin
          done_event = 1'b1;
          if (abort_req) begin
            abort_done = 1'b1;
            st_d       = WS_IDLE;
          end else if (cw_q[END_POS] && !poll_en) begin
            run_clr = 1'b1;
            st_d    = WS_IDLE;
          end else begin
            cur_d  = nxt_q[AW-1:0];
            beat_d = 2'd0;
            st_d   = WS_FETCH;
          end
        end
      end
      WS_POLL: begin
        polling = 1'b1;
        if (abort_req) begin
          abort_done = 1'b1;
          st_d       = WS_IDLE;
        end else if (poll_expire) begin
          beat_d = 2'd0;
          st_d   = WS_FETCH;
        end
      end
      default: st_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WS_IDLE;
      cur_q  <= '0;
      beat_q <= '0;
      nxt_q  <= '0;
      buf_q  <= '0;
      len_q  <= '0;
      cw_q   <= '0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      beat_q <= beat_d;
      nxt_q  <= nxt_d;
      buf_q  <= buf_d;
      len_q  <= len_d;
      cw_q   <= cw_d;
    end
  end
endmodule

// File: rtl/desc_walker.sv
module desc_walker
  import dw_pkg::*;
#(
  parameter int unsigned AW  = 32,
  parameter int unsigned PCW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mrd_req,
  output logic [AW-1:0] mrd_addr,
  input  logic          mrd_ack,
  input  logic [31:0]   mrd_data,
  output logic          mwr_req,
  output logic [AW-1:0] mwr_addr,
  output logic [31:0]   mwr_data,
  input  logic          mwr_ack,
  output logic          disp_valid,
  input  logic          disp_ready,
  output logic [31:0]   disp_addr,
  output logic [31:0]   disp_len,
  input  logic          disp_done,
  output logic          irq
);
  ctrl_bits_t     ctrl;
  logic [AW-1:0]  head_ptr;
  logic [PCW-1:0] poll_ivl;
  logic           irq_stat;
  logic           run_clr, abort_done, done_event;
  logic           poll_load, poll_expire, polling, own_flag;
  logic           run_bit, abort_bit, gie_bit;

  assign run_bit   = ctrl.run;
  assign abort_bit = ctrl.abort;
  assign gie_bit   = ctrl.gie;

  dw_regs #(.AW(AW), .PCW(PCW)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (reg_wr),
    .addr          (reg_addr),
    .wdata         (reg_wdata),
    .rdata         (reg_rdata),
    .hw_run_clr    (run_clr),
    .hw_abort_done (abort_done),
    .done_event    (done_event),
    .ctrl          (ctrl),
    .head_ptr      (head_ptr),
    .poll_ivl      (poll_ivl),
    .irq_stat      (irq_stat)
  );

  dw_poll_timer #(.PCW(PCW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (poll_load),
    .tick   (polling),
    .ivl    (poll_ivl),
    .expire (poll_expire)
  );

  dw_walker #(.AW(AW)) u_walk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run_bit),
    .poll_en     (ctrl.poll),
    .park        (ctrl.park),
    .abort_req   (abort_bit),
    .head_ptr    (head_ptr),
    .mrd_req     (mrd_req),
    .mrd_addr    (mrd_addr),
    .mrd_ack     (mrd_ack),
    .mrd_data    (mrd_data),
    .mwr_req     (mwr_req),
    .mwr_addr    (mwr_addr),
    .mwr_data    (mwr_data),
    .mwr_ack     (mwr_ack),
    .disp_valid  (disp_valid),
    .disp_ready  (disp_ready),
    .disp_addr   (disp_addr),
    .disp_len    (disp_len),
    .disp_done   (disp_done),
    .poll_expire (poll_expire),
    .poll_load   (poll_load),
    .polling     (polling),
    .run_clr     (run_clr),
    .abort_done  (abort_done),
    .done_event  (done_event),
    .own_flag    (own_flag)
  );

  assign irq = irq_stat & gie_bit;
endmodule

// File: rtl/desc_walker_chk.sv
module desc_walker_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mrd_req,
  input logic          mrd_ack,
  input logic [AW-1:0] mrd_addr,
  input logic          mwr_req,
  input logic          mwr_ack,
  input logic [AW-1:0] mwr_addr,
  input logic          disp_valid,
  input logic          own_flag,
  input logic          run_bit,
  input logic          abort_bit,
  input logic          gie_bit,
  input logic          irq_stat,
  input logic          polling
);
  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_req && !mrd_ack) |=> (mrd_req && $stable(mrd_addr)));

  // R4
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mwr_req && !mwr_ack) |=> (mwr_req && $stable(mwr_addr)));

  // R3
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mrd_req |-> !mwr_req);

  // R3
  own_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> own_flag);

  // R10
  abort_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(abort_bit) |-> !run_bit);

  // R7
  poll_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    polling |-> run_bit);

  // R11
  mask_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie_bit && !irq_stat) |=> !irq_stat);
endmodule

bind desc_walker desc_walker_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mrd_req    (mrd_req),
  .mrd_ack    (mrd_ack),
  .mrd_addr   (mrd_addr),
  .mwr_req    (mwr_req),
  .mwr_ack    (mwr_ack),
  .mwr_addr   (mwr_addr),
  .disp_valid (disp_valid),
  .own_flag   (own_flag),
  .run_bit    (run_bit),
  .abort_bit  (abort_bit),
  .gie_bit    (gie_bit),
  .irq_stat   (irq_stat),
  .polling    (polling)
);

// File: tb/desc_walker_bench.sv
`timescale 1ns/1ps
module desc_walker_bench;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          mrd_req;
  logic [AW-1:0] mrd_addr;
  logic          mrd_ack = 1'b0;
  logic [31:0]   mrd_data = '0;
  logic          mwr_req;
  logic [AW-1:0] mwr_addr;
  logic [31:0]   mwr_data;
  logic          mwr_ack = 1'b0;
  logic          disp_valid;
  logic          disp_ready = 1'b0;
  logic [31:0]   disp_addr;
  logic [31:0]   disp_len;
  logic          disp_done = 1'b0;
  logic          irq;

  desc_walker #(.AW(AW), .PCW(16)) u_desc_walker (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_ack(mrd_ack), .mrd_data(mrd_data),
    .mwr_req(mwr_req), .mwr_addr(mwr_addr), .mwr_data(mwr_data), .mwr_ack(mwr_ack),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_addr(disp_addr),
    .disp_len(disp_len), .disp_done(disp_done), .irq(irq)
  );

  always #4 clk = ~clk;

  logic [31:0] mem [0:255];
  logic [31:0] dl_addr [0:15];
  logic [31:0] dl_len  [0:15];
  int dn = 0, wb_n = 0, rd_beats = 0, rd_hold = 0, done_cnt = 0;
  int cyc = 0, ns = 0;
  int stamp [0:7];
  logic [31:0] watch_addr = 32'hFFFF_FFFF;
  logic hold_disp = 1'b0;
  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  // memory and dispatcher models, all driven at the falling edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    disp_done = 1'b0;
    if (done_cnt > 0 && !hold_disp) begin
      if (done_cnt == 1) disp_done = 1'b1;
      done_cnt = done_cnt - 1;
    end
    disp_ready = disp_valid;
    if (disp_valid) begin
      dl_addr[dn % 16] = disp_addr;
      dl_len[dn % 16]  = disp_len;
      dn = dn + 1;
      done_cnt = 3;
    end
    if (mrd_req && rd_hold == 0) begin
      mrd_ack  = 1'b1;
      mrd_data = mem[mrd_addr[9:2]];
      rd_beats = rd_beats + 1;
      if (mrd_addr == watch_addr && ns < 8) begin
        stamp[ns] = cyc;
        ns = ns + 1;
      end
    end else begin
      mrd_ack = 1'b0;
    end
    if (rd_hold > 0) rd_hold = rd_hold - 1;
    if (mwr_req) begin
      mwr_ack = 1'b1;
      mem[mwr_addr[9:2]] = mwr_data;
      wb_n = wb_n + 1;
    end else begin
      mwr_ack = 1'b0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_err = n_err + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic put_desc(input logic [31:0] at, input logic [31:0] nxt,
                          input logic [31:0] ba, input logic [31:0] len,
                          input logic [31:0] cw);
    mem[at[9:2]]       = nxt;
    mem[at[9:2] + 8'd1] = ba;
    mem[at[9:2] + 8'd2] = len;
    mem[at[9:2] + 8'd3] = cw;
  endtask

  task automatic wait_ctrl_zero(input int bitpos);
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      rd_reg(4'h0, v);
      if (!v[bitpos]) break;
    end
  endtask

  task automatic wait_dn(input int target);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (dn >= target) break;
    end
  endtask

  task automatic wait_ns(input int target);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (ns >= target) break;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk = n_chk + 1;
      n_err = n_err + 1;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int d0, rb0, wb0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset values
    rd_reg(4'h0, v); check("R1 ctrl", v, 32'h0);
    rd_reg(4'h4, v); check("R1 head", v, 32'h0);
    rd_reg(4'h8, v); check("R1 ivl", v, 32'h0);
    rd_reg(4'hC, v); check("R1 stat", v, 32'h0);
    // R1 reserved bits, R2 plain bits
    wr_reg(4'h0, 32'hFFFF_FFFA);
    rd_reg(4'h0, v); check("R1 R2 ctrl rw", v, 32'h0000_001A);
    wr_reg(4'h0, 32'h0);
    rd_reg(4'h0, v); check("R2 ctrl clear", v, 32'h0);

    // R3 R4 R5 three-descriptor chain
    put_desc(32'h040, 32'h080, 32'h1000, 32'd16, 32'h8000_0A00);
    put_desc(32'h080, 32'h0C0, 32'h2000, 32'd32, 32'h8000_0B00);
    put_desc(32'h0C0, 32'h3C0, 32'h3000, 32'd48, 32'h8000_0C01);
    wr_reg(4'h4, 32'h040);
    d0 = dn;
    wr_reg(4'h0, 32'h1);
    wait_ctrl_zero(0);
    check("R3 count", 32'(dn - d0), 32'd3);
    check("R3 addr0", dl_addr[d0 % 16], 32'h1000);
    check("R3 addr1", dl_addr[(d0 + 1) % 16], 32'h2000);
    check("R3 addr2", dl_addr[(d0 + 2) % 16], 32'h3000);
    check("R3 len1", dl_len[(d0 + 1) % 16], 32'd32);
    check("R4 wb0", mem[8'h13], 32'h0000_0A00);
    check("R4 wb2", mem[8'h33], 32'h0000_0C01);
    rb0 = rd_beats;
    repeat (20) @(negedge clk);
    check("R5 no reads after end", 32'(rd_beats), 32'(rb0));
    rd_reg(4'h0, v); check("R5 run cleared", v, 32'h0);

    // R11 events under a closed mask are not latched
    rd_reg(4'hC, v); check("R11 masked stat", v, 32'h0);
    wr_reg(4'h0, 32'h8);
    rd_reg(4'hC, v); check("R11 stat after unmask", v, 32'h0);
    check("R11 irq low", {31'b0, irq}, 32'h0);

    // R6 unowned head
    put_desc(32'h3C0, 32'h040, 32'h9000, 32'd4, 32'h0000_0001);
    wr_reg(4'h4, 32'h3C0);
    d0 = dn;
    wr_reg(4'h0, 32'h9);
    wait_ctrl_zero(0);
    check("R6 not dispatched", 32'(dn - d0), 32'd0);
    rd_reg(4'hC, v); check("R6 no completion", v, 32'h0);

    // R11 completion with mask open
    put_desc(32'h340, 32'h000, 32'h4000, 32'd8, 32'h8000_0001);
    wr_reg(4'h4, 32'h340);
    wr_reg(4'h0, 32'h9);
    wait_ctrl_zero(0);
    rd_reg(4'hC, v); check("R11 stat set", v, 32'h1);
    check("R11 irq high", {31'b0, irq}, 32'h1);
    wr_reg(4'hC, 32'h1);
    rd_reg(4'hC, v); check("R11 stat w1c", v, 32'h0);
    check("R11 irq cleared", {31'b0, irq}, 32'h0);

    // R2 writing 0 to run; R10 abort while dispatcher busy
    put_desc(32'h300, 32'h000, 32'h5000, 32'd8, 32'h8000_0001);
    wr_reg(4'h4, 32'h300);
    hold_disp = 1'b1;
    d0 = dn;
    wb0 = wb_n;
    wr_reg(4'h0, 32'h1);
    wait_dn(d0 + 1);
    wr_reg(4'h0, 32'h0);
    rd_reg(4'h0, v); check("R2 run ignores 0", v, 32'h1);
    wr_reg(4'h0, 32'h4);
    wait_ctrl_zero(2);
    rd_reg(4'h0, v); check("R10 busy abort clears", v, 32'h0);
    check("R10 no writeback", 32'(wb_n - wb0), 32'd0);
    hold_disp = 1'b0;
    done_cnt = 0;

    // R10 abort during a stalled read
    put_desc(32'h380, 32'h000, 32'h6000, 32'd8, 32'h8000_0001);
    wr_reg(4'h4, 32'h380);
    @(negedge clk); #1 rd_hold = 40;
    wr_reg(4'h0, 32'h1);
    repeat (5) @(negedge clk);
    wr_reg(4'h0, 32'h4);
    rd_reg(4'h0, v); check("R10 abort pending", v & 32'h5, 32'h5);
    check("R10 read held", {31'b0, mrd_req}, 32'h1);
    wait_ctrl_zero(2);
    rd_reg(4'h0, v); check("R10 abort done", v, 32'h0);
    rb0 = rd_beats;
    repeat (20) @(negedge clk);
    check("R10 no new reads", 32'(rd_beats), 32'(rb0));
    check("R10 req low", {31'b0, mrd_req}, 32'h0);

    // R7 polling with interval 3 then 0
    put_desc(32'h100, 32'h140, 32'h7000, 32'd12, 32'h8000_0001);
    put_desc(32'h140, 32'h180, 32'h7100, 32'd20, 32'h0000_0001);
    put_desc(32'h180, 32'h1C0, 32'h7200, 32'd24, 32'h0000_0001);
    wr_reg(4'h4, 32'h100);
    wr_reg(4'h8, 32'd3);
    @(negedge clk); #1 begin watch_addr = 32'h140; ns = 0; end
    wr_reg(4'h0, 32'h3);
    wait_ns(3);
    check("R7 period ivl3 a", 32'(stamp[1] - stamp[0]), 32'd8);
    check("R7 period ivl3 b", 32'(stamp[2] - stamp[1]), 32'd8);
    rd_reg(4'h0, v); check("R7 run held", v & 32'h1, 32'h1);
    wr_reg(4'h8, 32'd0);
    @(negedge clk); #1 ns = 0;
    wait_ns(3);
    check("R7 period ivl0", 32'(stamp[2] - stamp[1]), 32'd6);
    d0 = dn;
    @(negedge clk); #1 mem[8'h53] = 32'h8000_0001;
    wait_dn(d0 + 1);
    check("R7 resumed", dl_addr[d0 % 16], 32'h7100);
    repeat (10) @(negedge clk);
    rd_reg(4'h0, v); check("R7 run after resume", v & 32'h1, 32'h1);

    // R8 drop polling while waiting on descriptor at 0x180
    d0 = dn;
    wr_reg(4'h0, 32'h0);
    wait_ctrl_zero(0);
    rd_reg(4'h0, v); check("R8 stopped", v, 32'h0);
    check("R8 nothing dispatched", 32'(dn - d0), 32'd0);

    // R9 park mode ring
    put_desc(32'h200, 32'h240, 32'h8000, 32'd4, 32'h8000_0100);
    put_desc(32'h240, 32'h200, 32'h8100, 32'd4, 32'h8000_0200);
    wr_reg(4'h4, 32'h200);
    d0 = dn;
    wr_reg(4'h0, 32'h11);
    wait_dn(d0 + 6);
    check("R9 looped", {31'b0, dn >= d0 + 6}, 32'h1);
    check("R9 own kept", mem[8'h83], 32'h8000_0100);
    check("R9 alternate", dl_addr[(d0 + 5) % 16], 32'h8100);
    wr_reg(4'h0, 32'h0);
    wait_ctrl_zero(0);
    rd_reg(4'h0, v); check("R9 ring ended", v, 32'h0);
    check("R9 wb P", mem[8'h83], 32'h0000_0100);
    check("R9 wb Q", mem[8'h93], 32'h0000_0200);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule